// File: doc/BRIEF.md
# Interrupt Identification and Enable Unit

This block gathers the interrupt causes of an infrared communications controller into one identification register. Four causes are sticky event flags: a frame start, an end of message, a raw receive change and a busy medium. The fifth is a FIFO service flag driven by the transmit and receive service request levels. A matching enable register selects which flags may raise the single active-high interrupt request. A master enable input gates that request as a whole.

Software reads the identification register through a small register port. A read of that register, marked by the read strobe, clears the four event flags. The FIFO flag does not clear on a read. It follows its own enable instead: it can only set while that enable is on, and it drops when software turns the enable off. The event flags set whatever their enables hold. A masked flag can still be seen in the register, but it does not reach the request line.

Top module: `irq_ident_unit`

## Requirements
- R1: The identification register sits at address 1. Its bit 7 is frame start, bit 6 is end of message, bit 5 is raw receive, bit 4 is FIFO service and bit 3 is busy medium. rd_data shows the addressed register combinationally, in the same cycle as the address.
- R2: A cycle with rd_en high and rd_addr equal to 1 clears bits 7, 6, 5 and 3 at the clock edge that ends it. rd_data in that cycle still holds the values from before the clear.
- R3: The next value of the FIFO bit (bit 4) is the value enable bit 4 will hold after this cycle's write, ANDed with (the current FIFO bit OR tx_srv_req OR rx_srv_req). A read of the identification register leaves the FIFO bit unchanged, and writing 0 to enable bit 4 clears it.
- R4: A one-cycle pulse on ev_frame, ev_eom, ev_raw or ev_busy sets the matching bit at the next clock edge, whatever its enable holds. The bit then stays set until a clearing read.
- R5: irq is high exactly when master_en is high and at least one bit of the identification register is set with the same bit of the enable register set. irq follows those values combinationally.
- R6: The enable register sits at address 2. A cycle with wr_en high and rd_addr equal to 2 loads wr_data bits 7 to 3 at the clock edge. A 1 enables the interrupt in the same bit position of the identification register. Bits 2 to 0 are not stored and read back as 0.
- R7: While rst_n is low, every identification bit and every enable bit is 0, including the busy bit, so irq is low.
- R8: If an event pulse and a clearing read of its bit fall in the same cycle, the bit is set after the edge.
- R9: Bits 2 to 0 of the identification register always read 0. Any address other than 1 and 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master and power-on reset |
| ev_frame | input | 1 | Frame start event pulse |
| ev_eom | input | 1 | End of message event pulse |
| ev_raw | input | 1 | Raw receive event pulse |
| ev_busy | input | 1 | Busy medium event pulse |
| tx_srv_req | input | 1 | Transmit FIFO service request level |
| rx_srv_req | input | 1 | Receive FIFO service request level |
| rd_addr | input | 3 | Register address for reads and writes |
| rd_en | input | 1 | Read strobe; at address 1 it clears the event bits |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| master_en | input | 1 | Master interrupt enable |
| rd_data | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request, active high |

## Verification
Every stored bit changes at the clock edge that ends the cycle in which its event, read strobe or write is presented. The bench therefore drives each stimulus for one cycle between falling edges and checks the result after the following falling edge. rd_data and irq have no register of their own after the state, so a change of address or of master_en is checked a nanosecond later in the same cycle. The value returned by a clearing read is sampled during the strobe cycle, and the cleared result is read back one cycle later.

// File: rtl/iiu_pkg.sv
package iiu_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int N_STICKY  = 4;
    localparam int POS_FRAME = 7;
    localparam int POS_EOM   = 6;
    localparam int POS_RAW   = 5;
    localparam int POS_FIFO  = 4;
    localparam int POS_BUSY  = 3;
    localparam logic [DATA_W-1:0] LIVE_MASK = 8'hF8;

    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return POS_FRAME;
            1:       return POS_EOM;
            2:       return POS_RAW;
            default: return POS_BUSY;
        endcase
    endfunction
endpackage

// File: rtl/iiu_sticky_bit.sv
module iiu_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o); // R2
    AST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o)); // R4
endmodule

// File: rtl/iiu_fifo_bit.sv
module iiu_fifo_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic en_next_i,
    input  logic en_now_i,
    input  logic req_i,
    input  logic rd_clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = en_next_i & (flag_q | req_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    AST_FIFO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> en_now_i); // R3
    AST_FIFO_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && flag_o && en_next_i) |=> flag_o); // R3
endmodule

// File: rtl/iiu_irq_gate.sv
module iiu_irq_gate
    import iiu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] enable_i,
    input  logic              master_i,
    output logic              irq_o
);
    logic [DATA_W-1:0] armed;

    always_comb begin
        armed = status_i & enable_i;
        irq_o = master_i & (|armed);
    end

    AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> !irq_o); // R5
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((status_i & enable_i) != '0)); // R5
endmodule

// File: rtl/irq_ident_unit.sv
module irq_ident_unit
    import iiu_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ID_ADDR = 3'd1,
    parameter logic [ADDR_W-1:0] EN_ADDR = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_frame,
    input  logic              ev_eom,
    input  logic              ev_raw,
    input  logic              ev_busy,
    input  logic              tx_srv_req,
    input  logic              rx_srv_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              master_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] en;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [N_STICKY-1:0] events;
    logic              id_read;
    logic [DATA_W-1:0] status;

    assign events  = {ev_busy, ev_raw, ev_eom, ev_frame};
    assign id_read = rd_en && (rd_addr == ID_ADDR);

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (rd_addr == EN_ADDR))
            regs_d.en = wr_data & LIVE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    generate
        for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
            iiu_sticky_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (events[g]),
                .clr_i  (id_read),
                .flag_o (status[sticky_pos(g)])
            );
        end
    endgenerate

    iiu_fifo_bit u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_next_i (regs_d.en[POS_FIFO]),
        .en_now_i  (regs_q.en[POS_FIFO]),
        .req_i     (tx_srv_req | rx_srv_req),
        .rd_clr_i  (id_read),
        .flag_o    (status[POS_FIFO])
    );

    assign status[2:0] = 3'b000;

    iiu_irq_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .enable_i (regs_q.en),
        .master_i (master_en),
        .irq_o    (irq)
    );

    always_comb begin
        if (rd_addr == ID_ADDR)      rd_data = status;
        else if (rd_addr == EN_ADDR) rd_data = regs_q.en;
        else                         rd_data = '0;
    end

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2:0] == 3'b000); // R9
    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr == EN_ADDR) |=> (regs_q.en == ($past(wr_data) & LIVE_MASK))); // R6
endmodule

// File: tb/irq_ident_unit_bench.sv
`timescale 1ns/1ps
module irq_ident_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_frame = 0, ev_eom = 0, ev_raw = 0, ev_busy = 0;
    logic       tx_srv_req = 0, rx_srv_req = 0;
    logic [2:0] rd_addr = 3'd0;
    logic       rd_en = 0, wr_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic       master_en = 0;
    logic [7:0] rd_data;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_ident_unit u_irq_ident_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_frame(ev_frame), .ev_eom(ev_eom), .ev_raw(ev_raw), .ev_busy(ev_busy),
        .tx_srv_req(tx_srv_req), .rx_srv_req(rx_srv_req),
        .rd_addr(rd_addr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .master_en(master_en), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        rd_addr = a; wr_data = d; wr_en = 1;
        tick();
        wr_en = 0;
    endtask

    task automatic clr_read(output logic [7:0] v);
        rd_addr = 3'd1; rd_en = 1;
        #1 v = rd_data;
        tick();
        rd_en = 0;
    endtask

    task automatic pulse(input logic [3:0] m);
        {ev_busy, ev_raw, ev_eom, ev_frame} = m;
        tick();
        {ev_busy, ev_raw, ev_eom, ev_frame} = 4'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        pulse(4'b1111);
        rst_n = 0;
        #1;
        peek(3'd1, v); check("R7 id in reset", v, 8'h00);
        peek(3'd2, v); check("R7 en in reset", v, 8'h00);
        check("R7 irq in reset", {7'b0, irq}, 8'h00);
        tick(); rst_n = 1; tick();
    endtask

    task automatic t_events_masked();
        logic [7:0] v;
        master_en = 1;
        pulse(4'b0001); peek(3'd1, v); check("R4 frame sets", v, 8'h80);
        pulse(4'b1110); peek(3'd1, v); check("R4 other events set", v, 8'hE8);
        check("R5 masked no irq", {7'b0, irq}, 8'h00);
        clr_read(v); check("R2 read returns pre-clear", v, 8'hE8);
        peek(3'd1, v); check("R2 read cleared", v, 8'h00);
    endtask

    task automatic t_enable_irq();
        logic [7:0] v;
        wr(3'd2, 8'hFF); peek(3'd2, v); check("R6 enable readback", v, 8'hF8);
        wr(3'd2, 8'h40);
        pulse(4'b0001);
        check("R5 frame not enabled", {7'b0, irq}, 8'h00);
        pulse(4'b0010);
        check("R5 eom enabled irq", {7'b0, irq}, 8'h01);
        master_en = 0; #1;
        check("R5 master off", {7'b0, irq}, 8'h00);
        master_en = 1; #1;
        check("R5 master on", {7'b0, irq}, 8'h01);
        clr_read(v);
        check("R5 irq drops after read", {7'b0, irq}, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        tx_srv_req = 1; tick(); tx_srv_req = 0;
        peek(3'd1, v); check("R3 fifo needs enable", v, 8'h00);
        wr(3'd2, 8'h10);
        rx_srv_req = 1; tick(); rx_srv_req = 0;
        peek(3'd1, v); check("R3 fifo sets", v, 8'h10);
        check("R3 fifo irq", {7'b0, irq}, 8'h01);
        clr_read(v);
        peek(3'd1, v); check("R3 fifo survives read", v, 8'h10);
        wr(3'd2, 8'h00);
        peek(3'd1, v); check("R3 fifo cleared by disable", v, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        {ev_busy, ev_frame} = 2'b11;
        clr_read(v);
        {ev_busy, ev_frame} = 2'b00;
        peek(3'd1, v); check("R8 set wins over read", v, 8'h88);
        clr_read(v);
        peek(3'd1, v); check("R2 busy cleared", v, 8'h00);
    endtask

    task automatic t_addr();
        logic [7:0] v;
        pulse(4'b1111);
        peek(3'd1, v); check("R1 layout all events", v, 8'hE8);
        check("R9 low bits zero", {5'b0, v[2:0]}, 8'h00);
        peek(3'd5, v); check("R9 other address zero", v, 8'h00);
        peek(3'd0, v); check("R9 address 0 zero", v, 8'h00);
        clr_read(v);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_events_masked();
        t_enable_irq();
        t_fifo();
        t_set_wins();
        t_addr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule